// File: doc/BRIEF.md
# Sequential Unsigned Divider

This block divides one unsigned number by another, producing one quotient bit per clock with a restoring shift-and-subtract loop. A mode input picks the width. In narrow mode a single word is divided by a single word. In wide mode both the dividend and the divisor are two-word values: high word times 2^WORD_W plus low word. A one-cycle start request is taken only when the unit is not busy. The operands are captured on that edge, so the inputs may change freely afterwards. The unit raises `busy` while it iterates and pulses `done` when the result registers have been updated.

A divisor of zero never traps. It is detected on the start edge and finishes at once with a fixed result: every quotient bit is set, and the original dividend is returned in the remainder words. The result registers keep their value until the next operation completes.

The controller has three states. `ST_IDLE` waits for a start. `ST_CALC` runs one restoring step per cycle. `ST_DONE` lasts one cycle and drives `done`. The transitions are:
- *accept-zero*: `ST_IDLE` or `ST_DONE` to `ST_DONE`, on a start with a zero divisor.
- *accept-run*: `ST_IDLE` or `ST_DONE` to `ST_CALC`, on a start with a nonzero divisor.
- *last-step*: `ST_CALC` to `ST_DONE`, when the step counter reaches zero.
- *retire*: `ST_DONE` to `ST_IDLE`, when no start is present.

Top module: `udiv_seq`

## Requirements
- R1: In narrow mode (`wide_mode`=0) with `dvs_lo` nonzero, the unit returns `quo_lo` = `dvd_lo` / `dvs_lo` and `rem_lo` = `dvd_lo` mod `dvs_lo`. Both `quo_hi` and `rem_hi` read zero, and `dvd_hi` and `dvs_hi` have no effect on the result.
- R2: In wide mode (`wide_mode`=1) the dividend is {`dvd_hi`,`dvd_lo`} and the divisor is {`dvs_hi`,`dvs_lo`}. For a nonzero divisor the unit returns the unsigned quotient as {`quo_hi`,`quo_lo`} and the remainder as {`rem_hi`,`rem_lo`}.
- R3: For a nonzero divisor, take the clock edge that samples `start` as edge k. `busy` is high in the WORD_W (narrow) or 2*WORD_W (wide) cycles that follow edge k. `done` is then high for exactly one cycle, starting at edge k+WORD_W or edge k+2*WORD_W.
- R4: In narrow mode with `dvs_lo`=0, `done` is high in the cycle right after the start edge and `busy` never rises. The result is `quo_lo`=all ones, `rem_lo`=`dvd_lo`, and `quo_hi`=`rem_hi`=0, whatever value `dvs_hi` holds.
- R5: In wide mode with both divisor words zero, `done` is high in the cycle right after the start edge and `busy` never rises. The result is `quo_lo`=`quo_hi`=all ones, `rem_lo`=`dvd_lo` and `rem_hi`=`dvd_hi`.
- R6: A start sampled while `busy` is high is ignored. The running operation finishes on its original schedule with the results of its original operands.
- R7: The four result words change only on the edge that raises `done`. They hold their values in every cycle in which `done` is low, whatever the operand inputs do.
- R8: While `rst_n` is low and after its release, `busy`=0, `done`=0 and all result words are zero.
- R9: `busy` and `done` are never high together. A start sampled in the `done` cycle is accepted as a new operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start request, sampled when not busy |
| wide_mode | input | 1 | 1 selects two-word operands, 0 selects one-word operands |
| dvd_lo | input | WORD_W | Dividend low word (the whole dividend in narrow mode) |
| dvd_hi | input | WORD_W | Dividend high word (wide mode only) |
| dvs_lo | input | WORD_W | Divisor low word (the whole divisor in narrow mode) |
| dvs_hi | input | WORD_W | Divisor high word (wide mode only) |
| quo_lo | output | WORD_W | Quotient low word |
| quo_hi | output | WORD_W | Quotient high word (zero in narrow mode) |
| rem_lo | output | WORD_W | Remainder low word |
| rem_hi | output | WORD_W | Remainder high word (zero in narrow mode) |
| busy | output | 1 | High while iterating |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong step count or a wrong counter load shows up as a `done` pulse that arrives one or more cycles early or late. The bench sees this on the very operation where it happens, because it measures the distance from the start edge to `done` and counts the `busy` cycles. A corrupted partial remainder or a misaligned narrow dividend has no effect on timing. It only appears as a wrong quotient or remainder at the `done` cycle, so every result is compared against an independent computation, including all-ones, unit and zero-divisor operands. Leaking operand state would surface later: in result words that drift between operations, or in an injected start during `busy` that changes a result.

// File: rtl/udiv_pkg.sv
package udiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_DONE = 2'd2
    } udiv_state_e;

endpackage

// File: rtl/udiv_ctrl.sv
module udiv_ctrl
    import udiv_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int LONG_W = 2 * WORD_W,
    localparam int CNT_W  = $clog2(LONG_W)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic wide_mode,
    input  logic div_zero,
    output logic load_ops,
    output logic step_en,
    output logic commit_calc,
    output logic commit_zero,
    output logic busy,
    output logic done
);

    udiv_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             accept;
    logic             last_step;

    assign accept    = start && (state_q != ST_CALC);
    assign last_step = (cnt_q == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (accept) begin
                    state_d = div_zero ? ST_DONE : ST_CALC;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_CALC: begin
                if (last_step) begin
                    state_d = ST_DONE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (accept && !div_zero) begin
            cnt_q <= wide_mode ? CNT_W'(LONG_W - 1) : CNT_W'(WORD_W - 1);
        end else if (state_q == ST_CALC && !last_step) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        load_ops    = accept && !div_zero;
        commit_zero = accept && div_zero;
        step_en     = (state_q == ST_CALC);
        commit_calc = (state_q == ST_CALC) && last_step;
        busy        = (state_q == ST_CALC);
        done        = (state_q == ST_DONE);
    end

endmodule

// File: rtl/udiv_step.sv
module udiv_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] part_i,
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] dvs_i,
    output logic [W-1:0] part_o,
    output logic [W-1:0] quo_o
);

    logic [W:0] shifted;
    logic [W:0] trial;
    logic       fits;

    always_comb begin
        shifted = {part_i, quo_i[W-1]};
        trial   = shifted - {1'b0, dvs_i};
        fits    = !trial[W];
        part_o  = fits ? trial[W-1:0] : shifted[W-1:0];
        quo_o   = {quo_i[W-2:0], fits};
    end

endmodule

// File: rtl/udiv_datapath.sv
module udiv_datapath #(
    parameter int WORD_W = 16,
    localparam int LONG_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode,
    input  logic [WORD_W-1:0] dvd_lo,
    input  logic [WORD_W-1:0] dvd_hi,
    input  logic [WORD_W-1:0] dvs_lo,
    input  logic [WORD_W-1:0] dvs_hi,
    input  logic              load_ops,
    input  logic              step_en,
    input  logic              commit_calc,
    input  logic              commit_zero,
    output logic [WORD_W-1:0] quo_lo,
    output logic [WORD_W-1:0] quo_hi,
    output logic [WORD_W-1:0] rem_lo,
    output logic [WORD_W-1:0] rem_hi
);

    logic [LONG_W-1:0] part_q, quo_q, dvs_q;
    logic [LONG_W-1:0] part_nx, quo_nx;
    logic              wide_q;

    udiv_step #(.W(LONG_W)) u_step (
        .part_i (part_q),
        .quo_i  (quo_q),
        .dvs_i  (dvs_q),
        .part_o (part_nx),
        .quo_o  (quo_nx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            part_q <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            wide_q <= 1'b0;
        end else if (load_ops) begin
            part_q <= '0;
            wide_q <= wide_mode;
            if (wide_mode) begin
                quo_q <= {dvd_hi, dvd_lo};
                dvs_q <= {dvs_hi, dvs_lo};
            end else begin
                quo_q <= {dvd_lo, {WORD_W{1'b0}}};
                dvs_q <= {{WORD_W{1'b0}}, dvs_lo};
            end
        end else if (step_en) begin
            part_q <= part_nx;
            quo_q  <= quo_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quo_lo <= '0;
            quo_hi <= '0;
            rem_lo <= '0;
            rem_hi <= '0;
        end else if (commit_zero) begin
            quo_lo <= '1;
            quo_hi <= wide_mode ? {WORD_W{1'b1}} : {WORD_W{1'b0}};
            rem_lo <= dvd_lo;
            rem_hi <= wide_mode ? dvd_hi : {WORD_W{1'b0}};
        end else if (commit_calc) begin
            quo_lo <= quo_nx[WORD_W-1:0];
            rem_lo <= part_nx[WORD_W-1:0];
            quo_hi <= wide_q ? quo_nx[LONG_W-1:WORD_W]  : {WORD_W{1'b0}};
            rem_hi <= wide_q ? part_nx[LONG_W-1:WORD_W] : {WORD_W{1'b0}};
        end
    end

endmodule

// File: rtl/udiv_seq.sv
module udiv_seq #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wide_mode,
    input  logic [WORD_W-1:0] dvd_lo,
    input  logic [WORD_W-1:0] dvd_hi,
    input  logic [WORD_W-1:0] dvs_lo,
    input  logic [WORD_W-1:0] dvs_hi,
    output logic [WORD_W-1:0] quo_lo,
    output logic [WORD_W-1:0] quo_hi,
    output logic [WORD_W-1:0] rem_lo,
    output logic [WORD_W-1:0] rem_hi,
    output logic              busy,
    output logic              done
);

    logic div_zero;
    logic load_ops, step_en, commit_calc, commit_zero;

    assign div_zero = wide_mode ? ({dvs_hi, dvs_lo} == '0) : (dvs_lo == '0);

    udiv_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .wide_mode   (wide_mode),
        .div_zero    (div_zero),
        .load_ops    (load_ops),
        .step_en     (step_en),
        .commit_calc (commit_calc),
        .commit_zero (commit_zero),
        .busy        (busy),
        .done        (done)
    );

    udiv_datapath #(.WORD_W(WORD_W)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .wide_mode   (wide_mode),
        .dvd_lo      (dvd_lo),
        .dvd_hi      (dvd_hi),
        .dvs_lo      (dvs_lo),
        .dvs_hi      (dvs_hi),
        .load_ops    (load_ops),
        .step_en     (step_en),
        .commit_calc (commit_calc),
        .commit_zero (commit_zero),
        .quo_lo      (quo_lo),
        .quo_hi      (quo_hi),
        .rem_lo      (rem_lo),
        .rem_hi      (rem_hi)
    );

endmodule

// File: rtl/udiv_checker.sv
module udiv_checker #(
    parameter int WORD_W = 16,
    localparam int LONG_W = 2 * WORD_W,
    localparam int PROD_W = 2 * LONG_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              wide_mode,
    input logic [WORD_W-1:0] dvd_lo,
    input logic [WORD_W-1:0] dvd_hi,
    input logic [WORD_W-1:0] dvs_lo,
    input logic [WORD_W-1:0] dvs_hi,
    input logic [WORD_W-1:0] quo_lo,
    input logic [WORD_W-1:0] quo_hi,
    input logic [WORD_W-1:0] rem_lo,
    input logic [WORD_W-1:0] rem_hi,
    input logic              busy,
    input logic              done
);

    logic              took;
    logic              m_wide;
    logic [LONG_W-1:0] a_cap, b_cap;
    logic [LONG_W:0]   run_len;
    logic [PROD_W-1:0] recon;
    logic [LONG_W-1:0] q_all, r_all;

    assign took = start && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_wide  <= 1'b0;
            a_cap   <= '0;
            b_cap   <= '0;
            run_len <= '0;
        end else if (took) begin
            m_wide  <= wide_mode;
            a_cap   <= wide_mode ? {dvd_hi, dvd_lo} : {{WORD_W{1'b0}}, dvd_lo};
            b_cap   <= wide_mode ? {dvs_hi, dvs_lo} : {{WORD_W{1'b0}}, dvs_lo};
            run_len <= '0;
        end else if (busy) begin
            run_len <= run_len + 1'b1;
        end
    end

    always_comb begin
        q_all = {quo_hi, quo_lo};
        r_all = {rem_hi, rem_lo};
        recon = PROD_W'(q_all) * PROD_W'(b_cap) + PROD_W'(r_all);
    end

    p_div_ok_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done && !m_wide && b_cap != '0 |->
            quo_hi == '0 && rem_hi == '0 && recon == PROD_W'(a_cap) && r_all < b_cap);

    p_div_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done && m_wide && b_cap != '0 |->
            recon == PROD_W'(a_cap) && r_all < b_cap);

    p_one_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done || $past(start)));

    p_run_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done && $past(busy) |->
            run_len == (m_wide ? (LONG_W + 1)'(LONG_W) : (LONG_W + 1)'(WORD_W)));

    p_zero_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && !wide_mode && dvs_lo == '0 |=>
            done && !busy && quo_lo == '1 && quo_hi == '0 &&
            rem_lo == $past(dvd_lo) && rem_hi == '0);

    p_zero_wide_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && wide_mode && dvs_lo == '0 && dvs_hi == '0 |=>
            done && !busy && quo_lo == '1 && quo_hi == '1 &&
            rem_lo == $past(dvd_lo) && rem_hi == $past(dvd_hi));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({quo_hi, quo_lo, rem_hi, rem_lo}));

    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

endmodule

bind udiv_seq udiv_checker #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .wide_mode (wide_mode),
    .dvd_lo    (dvd_lo),
    .dvd_hi    (dvd_hi),
    .dvs_lo    (dvs_lo),
    .dvs_hi    (dvs_hi),
    .quo_lo    (quo_lo),
    .quo_hi    (quo_hi),
    .rem_lo    (rem_lo),
    .rem_hi    (rem_hi),
    .busy      (busy),
    .done      (done)
);

// File: tb/udiv_seq_tb.sv
module udiv_seq_tb;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         wide_mode = 1'b0;
    logic [W-1:0] dvd_lo = '0, dvd_hi = '0, dvs_lo = '0, dvs_hi = '0;
    logic [W-1:0] quo_lo, quo_hi, rem_lo, rem_hi;
    logic         busy, done;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    udiv_seq #(.WORD_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .wide_mode(wide_mode),
        .dvd_lo(dvd_lo), .dvd_hi(dvd_hi), .dvs_lo(dvs_lo), .dvs_hi(dvs_hi),
        .quo_lo(quo_lo), .quo_hi(quo_hi), .rem_lo(rem_lo), .rem_hi(rem_hi),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_result(input bit wide,
            input logic [W-1:0] al, ah, bl, bh);
        logic [31:0] a, b, q, r;
        a = wide ? {ah, al} : {16'h0, al};
        b = wide ? {bh, bl} : {16'h0, bl};
        if (b == 0) begin
            q = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
            r = a;
        end else begin
            q = a / b;
            r = a % b;
        end
        return {q, r};
    endfunction

    task automatic scramble();
        dvd_lo = W'($urandom); dvd_hi = W'($urandom);
        dvs_lo = W'($urandom); dvs_hi = W'($urandom);
        wide_mode = 1'($urandom);
    endtask

    // Called at a negedge; returns at the negedge where done is observed.
    task automatic do_op(input bit wide, input logic [W-1:0] al, ah, bl, bh,
                         input bit inject);
        logic [63:0] e;
        logic [31:0] b;
        bit          zero;
        int          lat, bcnt, exp_lat;
        string       vreq;
        e    = exp_result(wide, al, ah, bl, bh);
        b    = wide ? {bh, bl} : {16'h0, bl};
        zero = (b == 0);
        exp_lat = zero ? 1 : (wide ? 2 * W + 1 : W + 1);
        vreq = zero ? (wide ? "R5" : "R4") : (wide ? "R2" : "R1");
        wide_mode = wide; dvd_lo = al; dvd_hi = ah; dvs_lo = bl; dvs_hi = bh;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        scramble();
        lat = 0; bcnt = 0;
        for (int i = 1; i <= 80; i++) begin
            if (done) begin
                lat = i;
                break;
            end
            if (busy) bcnt++;
            if (inject && i == 3) begin
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        if (lat == 0) begin
            chk(1'b0, "R3", "watchdog: no done", 64'(lat), 64'(exp_lat));
        end else begin
            chk(lat == exp_lat, zero ? vreq : "R3", "done latency", 64'(lat), 64'(exp_lat));
            chk(bcnt == exp_lat - 1, zero ? vreq : "R3", "busy cycles", 64'(bcnt), 64'(exp_lat - 1));
            chk(!busy, "R9", "busy with done", 64'(busy), 64'd0);
            chk({quo_hi, quo_lo} == e[63:32], inject ? "R6" : vreq, "quotient",
                64'({quo_hi, quo_lo}), 64'(e[63:32]));
            chk({rem_hi, rem_lo} == e[31:0], inject ? "R6" : vreq, "remainder",
                64'({rem_hi, rem_lo}), 64'(e[31:0]));
        end
    endtask

    task automatic hold_test();
        logic [63:0] snap;
        snap = {quo_hi, quo_lo, rem_hi, rem_lo};
        @(negedge clk);
        chk(!done, "R3", "done pulse width", 64'(done), 64'd0);
        for (int i = 0; i < 5; i++) begin
            scramble();
            @(negedge clk);
        end
        chk({quo_hi, quo_lo, rem_hi, rem_lo} == snap, "R7", "result hold",
            {quo_hi, quo_lo, rem_hi, rem_lo}, snap);
    endtask

    initial begin
        #(4 * 200000);
        chk(1'b0, "R3", "global watchdog", 64'd0, 64'd1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk({busy, done, quo_lo, quo_hi, rem_lo, rem_hi} == '0, "R8", "reset state",
            64'({busy, done, quo_lo, quo_hi, rem_lo, rem_hi}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, quo_lo, quo_hi, rem_lo, rem_hi} == '0, "R8", "after release",
            64'({busy, done, quo_lo, quo_hi, rem_lo, rem_hi}), 64'd0);

        // Directed corners
        do_op(1'b0, 16'd100, 16'hABCD, 16'd7, 16'h1234, 1'b0);   // R1 hi words ignored
        hold_test();                                            // R7
        do_op(1'b0, 16'hFFFF, 16'h0, 16'd1, 16'h0, 1'b0);
        do_op(1'b0, 16'hFFFF, 16'h0, 16'hFFFF, 16'h0, 1'b0);   // R9 back-to-back start
        do_op(1'b0, 16'd5, 16'h0, 16'hFFFF, 16'h0, 1'b0);
        do_op(1'b0, 16'h1357, 16'h0, 16'h0, 16'h00FF, 1'b0);   // R4 dvs_hi ignored
        do_op(1'b0, 16'h2468, 16'h0, 16'h0, 16'h0, 1'b0);      // R4 then R9 back-to-back
        do_op(1'b1, 16'hFFFF, 16'hFFFF, 16'd1, 16'd0, 1'b0);   // R2
        do_op(1'b1, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0);
        do_op(1'b1, 16'h0000, 16'h0001, 16'h0000, 16'h0001, 1'b0);
        do_op(1'b1, 16'hBEEF, 16'hCAFE, 16'h0, 16'h0, 1'b0);   // R5
        hold_test();
        do_op(1'b1, 16'h1234, 16'h5678, 16'h0003, 16'h0000, 1'b1); // R6
        do_op(1'b0, 16'h9999, 16'h0, 16'h0011, 16'h0, 1'b1);       // R6

        // Constrained random
        for (int k = 0; k < 60; k++) begin
            bit w;
            logic [W-1:0] al, ah, bl, bh;
            w  = (k >= 30);
            al = W'($urandom); ah = W'($urandom);
            bl = W'($urandom); bh = W'($urandom);
            if ($urandom_range(0, 3) == 0) bh = '0;
            if ($urandom_range(0, 3) == 0) bl = W'($urandom_range(1, 15));
            if ($urandom_range(0, 7) == 0) begin bl = '0; bh = '0; end
            do_op(w, al, ah, bl, bh, (k % 4) == 3);
            if ((k % 10) == 9) hold_test();
        end

        @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule